// File: doc/BRIEF.md
# Memory Error Capture and Report Unit

This unit sits beside a memory controller and records the first memory error it sees. Each cycle it receives four error flags from an external checker, plus the virtual address, the context number and a flag that tells whether the current access is a DMA cycle or a processor cycle. A build-time parameter selects parity mode or ECC mode, and the mode sets what the four flags mean. In parity mode each flag reports one byte lane. In ECC mode the flags are the correctable, uncorrectable, write-back error and write-back timeout causes.

When an error is accepted, the unit freezes a 32-bit address word and the cause bits, and sets a pending bit. The address word holds the access flag and context in its top nibble and the virtual address below it. The interrupt output is high while an error is pending and interrupts are enabled. The interrupt is always tagged with the top, non-maskable priority level. Software reads a status/control register and the address register over a single-cycle register port. Any write to the address register acknowledges the error and releases the interrupt.

Top module: `memfault_capture`

## Requirements
- R1: After reset, the status/control read (reg_sel=0) returns 0, the address read (reg_sel=1) returns 0 and irq is low.
- R2: The status/control layout is as follows. Bit 0 is the interrupt enable and bit 1 is the mode enable (parity check enable in parity mode, correctable-error enable in ECC mode). Both are written from reg_wdata[1:0] when reg_wr=1 and reg_sel=0. Bits 5:2 are the captured cause and bit 7 is pending. Software cannot write bits 7:2, and bit 6 and all bits above 7 read as 0.
- R3: If an accepted error arrives while nothing is pending, the next cycle shows pending=1, the cause bits of that cycle, and the address word {acc_dvma, acc_ctx[2:0], acc_vaddr[27:0]} on the address read.
- R4: In parity mode, err_flags[i] is lane i and is latched into status bit 2+i. Flags are accepted only while the mode enable (bit 1) is 1.
- R5: In ECC mode, err_flags[0]=correctable, [1]=uncorrectable, [2]=write-back error and [3]=write-back timeout, shown in status bits 2, 3, 4 and 5. The last three are accepted whatever the enables hold.
- R6: In ECC mode, a correctable flag is accepted (and shown) only while the mode enable (bit 1) is 1. Otherwise it leaves the unit unchanged.
- R7: irq is high exactly when pending=1 and the interrupt enable is 1. irq_level always reads 7.
- R8: While pending=1, new error flags change neither the address word nor the cause bits, until an acknowledge.
- R9: A write with reg_sel=1 (any data) clears pending and the cause bits on the next cycle, which drops irq. The enables are left as they were.
- R10: If an acknowledge and an accepted error fall in the same cycle, the new error is captured and pending stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| err_flags | input | 4 | Error flags from the checker (meaning set by mode) |
| acc_vaddr | input | VA_W (28) | Virtual address of the current access |
| acc_ctx | input | 3 | Context number of the current access |
| acc_dvma | input | 1 | 1 = DMA cycle, 0 = processor cycle |
| reg_sel | input | 1 | 0 = status/control, 1 = error address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 2 | Enable bits written to status/control |
| reg_rdata | output | VA_W+4 (32) | Read data for the selected register |
| irq | output | 1 | Level interrupt request |
| irq_level | output | 3 | Priority level of the interrupt (constant 7) |

## Verification
The critical overlap is an acknowledge (a write to the address register) in the same cycle as a new accepted error. In that cycle the clear and the capture both want to update the pending bit and the captured state. The bench provokes this overlap with directed cycles in both parity and ECC builds. It also lets constrained-random traffic hit it by chance. A bench-side model applies the rule that the new error wins, and the bench compares status, address and irq in the following cycle.

// File: rtl/memfault_pkg.sv
package memfault_pkg;
  localparam int CAUSE_W   = 4;
  localparam int CTX_W     = 3;
  localparam int TAG_W     = CTX_W + 1;
  localparam int CSR_W     = 8;
  localparam int EN_W      = 2;
  localparam int B_IE      = 0;
  localparam int B_EN      = 1;
  localparam int B_CAUSE   = 2;
  localparam int B_PEND    = 7;
  localparam logic [2:0] IRQ_PRIO = 3'd7;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_ADDR   = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/memfault_ctrl.sv
module memfault_ctrl
  import memfault_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csr_wr,
  input  logic [EN_W-1:0] wdata,
  output logic            ie_q,
  output logic            en_q
);
  logic ie_d, en_d;

  always_comb begin
    ie_d = ie_q;
    en_d = en_q;
    if (csr_wr) begin
      ie_d = wdata[B_IE];
      en_d = wdata[B_EN];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q <= 1'b0;
      en_q <= 1'b0;
    end else if (csr_wr) begin
      ie_q <= ie_d;
      en_q <= en_d;
    end
  end
endmodule

// File: rtl/memfault_detect.sv
module memfault_detect
  import memfault_pkg::*;
#(
  parameter bit ECC_MODE = 1'b1
) (
  input  logic [CAUSE_W-1:0] err_flags,
  input  logic               en_q,
  output logic [CAUSE_W-1:0] cause_in,
  output logic               err_event
);
  generate
    if (ECC_MODE) begin : g_ecc
      // correctable cause (flag 0) gated by its own enable; others always taken
      always_comb begin
        cause_in    = err_flags;
        cause_in[0] = err_flags[0] & en_q;
      end
    end else begin : g_par
      // every lane gated by the parity check enable
      always_comb begin
        cause_in = err_flags & {CAUSE_W{en_q}};
      end
    end
  endgenerate

  assign err_event = |cause_in;
endmodule

// File: rtl/memfault_latch.sv
module memfault_latch
  import memfault_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               err_event,
  input  logic [CAUSE_W-1:0] cause_in,
  input  logic [ADDR_W-1:0]  addr_in,
  input  logic               ack,
  output logic               pend_q,
  output logic [CAUSE_W-1:0] cause_q,
  output logic [ADDR_W-1:0]  cap_addr_q
);
  logic               take;
  logic               upd;
  logic               pend_d;
  logic [CAUSE_W-1:0] cause_d;
  logic [ADDR_W-1:0]  addr_d;

  // a new error wins over a same-cycle acknowledge
  assign take = err_event & (~pend_q | ack);
  assign upd  = take | ack;

  always_comb begin
    pend_d  = pend_q;
    cause_d = cause_q;
    addr_d  = cap_addr_q;
    if (take) begin
      pend_d  = 1'b1;
      cause_d = cause_in;
      addr_d  = addr_in;
    end else if (ack) begin
      pend_d  = 1'b0;
      cause_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      cause_q    <= '0;
      cap_addr_q <= '0;
    end else if (upd) begin
      pend_q     <= pend_d;
      cause_q    <= cause_d;
      cap_addr_q <= addr_d;
    end
  end
endmodule

// File: rtl/memfault_capture.sv
module memfault_capture
  import memfault_pkg::*;
#(
  parameter bit ECC_MODE = 1'b1,
  parameter int VA_W     = 28,
  localparam int ADDR_W  = VA_W + TAG_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CAUSE_W-1:0] err_flags,
  input  logic [VA_W-1:0]    acc_vaddr,
  input  logic [CTX_W-1:0]   acc_ctx,
  input  logic               acc_dvma,
  input  logic               reg_sel,
  input  logic               reg_wr,
  input  logic [EN_W-1:0]    reg_wdata,
  output logic [ADDR_W-1:0]  reg_rdata,
  output logic               irq,
  output logic [2:0]         irq_level
);
  logic [1:0]         rst_sync_q;
  logic               rst_q_n;
  logic               ie_q, en_q;
  logic               csr_wr, ack;
  logic               err_event;
  logic [CAUSE_W-1:0] cause_in, cause_q;
  logic               pend_q;
  logic [ADDR_W-1:0]  addr_in, cap_addr_q;
  logic [CSR_W-1:0]   status;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  assign csr_wr  = reg_wr & (reg_sel == SEL_STATUS);
  assign ack     = reg_wr & (reg_sel == SEL_ADDR);
  assign addr_in = {acc_dvma, acc_ctx, acc_vaddr};

  memfault_ctrl i_ctrl (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .csr_wr (csr_wr),
    .wdata  (reg_wdata),
    .ie_q   (ie_q),
    .en_q   (en_q)
  );

  memfault_detect #(.ECC_MODE(ECC_MODE)) i_detect (
    .err_flags (err_flags),
    .en_q      (en_q),
    .cause_in  (cause_in),
    .err_event (err_event)
  );

  memfault_latch #(.ADDR_W(ADDR_W)) i_latch (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .err_event  (err_event),
    .cause_in   (cause_in),
    .addr_in    (addr_in),
    .ack        (ack),
    .pend_q     (pend_q),
    .cause_q    (cause_q),
    .cap_addr_q (cap_addr_q)
  );

  always_comb begin
    status                         = '0;
    status[B_IE]                   = ie_q;
    status[B_EN]                   = en_q;
    status[B_CAUSE +: CAUSE_W]     = cause_q;
    status[B_PEND]                 = pend_q;
  end

  always_comb begin
    if (reg_sel == SEL_ADDR) reg_rdata = cap_addr_q;
    else                     reg_rdata = {{(ADDR_W-CSR_W){1'b0}}, status};
  end

  assign irq       = ie_q & pend_q;
  assign irq_level = IRQ_PRIO;
endmodule

// File: rtl/memfault_checker.sv
module memfault_checker
  import memfault_pkg::*;
#(
  parameter bit ECC_MODE = 1'b1,
  parameter int ADDR_W   = 32
) (
  input logic               clk,
  input logic               rst_q_n,
  input logic               reg_wr,
  input logic               reg_sel,
  input logic [CAUSE_W-1:0] err_flags,
  input logic               err_event,
  input logic               pend_q,
  input logic [CAUSE_W-1:0] cause_q,
  input logic [ADDR_W-1:0]  cap_addr_q,
  input logic               en_q,
  input logic               ie_q,
  input logic               irq
);
  a_r3_capture: assert property (@(posedge clk) disable iff (!rst_q_n)
    (err_event && !pend_q) |=> (pend_q && cause_q != '0));

  a_r3_cause_with_pend: assert property (@(posedge clk) disable iff (!rst_q_n)
    pend_q == (cause_q != '0));

  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_q_n)
    (pend_q && !(reg_wr && reg_sel)) |=> (pend_q && $stable(cap_addr_q) && $stable(cause_q)));

  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_q_n)
    (reg_wr && reg_sel && !err_event) |=> (!pend_q && cause_q == '0 && !irq));

  a_r10_ack_and_new: assert property (@(posedge clk) disable iff (!rst_q_n)
    (reg_wr && reg_sel && err_event) |=> pend_q);

  a_r6_ce_gated: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ECC_MODE && !en_q && !pend_q && err_flags == 4'b0001) |=> !pend_q);

  a_r4_par_gated: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!ECC_MODE && !en_q && !pend_q) |=> !pend_q);

  a_r7_irq_release: assert property (@(posedge clk) disable iff (!rst_q_n)
    ($fell(pend_q) || $fell(ie_q)) |-> !irq);
endmodule

bind memfault_capture memfault_checker #(.ECC_MODE(ECC_MODE), .ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_memfault_capture.sv
module test_memfault_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  err_flags = '0;
  logic [27:0] acc_vaddr = '0;
  logic [2:0]  acc_ctx = '0;
  logic        acc_dvma = 1'b0;
  logic        reg_sel = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_wdata = '0;
  logic [31:0] rd_e, rd_p;
  logic        irq_e, irq_p;
  logic [2:0]  lvl_e, lvl_p;

  int n_chk = 0;
  int n_fail = 0;

  // model state: index 0 = ECC build, 1 = parity build
  logic        m_ie[2], m_en[2], m_pend[2];
  logic [3:0]  m_cause[2];
  logic [31:0] m_addr[2];

  always #4 clk = ~clk;

  memfault_capture #(.ECC_MODE(1'b1)) i_memfault_capture (
    .clk(clk), .rst_n(rst_n), .err_flags(err_flags), .acc_vaddr(acc_vaddr),
    .acc_ctx(acc_ctx), .acc_dvma(acc_dvma), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(rd_e), .irq(irq_e), .irq_level(lvl_e));

  memfault_capture #(.ECC_MODE(1'b0)) i_memfault_capture_par (
    .clk(clk), .rst_n(rst_n), .err_flags(err_flags), .acc_vaddr(acc_vaddr),
    .acc_ctx(acc_ctx), .acc_dvma(acc_dvma), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(rd_p), .irq(irq_p), .irq_level(lvl_p));

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [3:0] accepted(int m, logic [3:0] f);
    if (m == 0) return {f[3:1], f[0] & m_en[0]};
    return f & {4{m_en[1]}};
  endfunction

  function automatic logic [31:0] exp_status(int m);
    return {24'h0, m_pend[m], 1'b0, m_cause[m], m_en[m], m_ie[m]};
  endfunction

  task automatic model_step(logic wr, logic sel, logic [1:0] wd, logic [3:0] f,
                            logic dv, logic [2:0] cx, logic [27:0] va);
    for (int m = 0; m < 2; m++) begin
      logic [3:0] c;
      logic ack;
      c   = accepted(m, f);
      ack = wr && sel;
      if (c != 0 && (!m_pend[m] || ack)) begin
        m_pend[m]  = 1'b1;
        m_cause[m] = c;
        m_addr[m]  = {dv, cx, va};
      end else if (ack) begin
        m_pend[m]  = 1'b0;
        m_cause[m] = '0;
      end
      if (wr && !sel) begin
        m_ie[m] = wd[0];
        m_en[m] = wd[1];
      end
    end
  endtask

  // called just after a falling edge; returns just after the next falling edge
  task automatic cyc(string tag, logic wr, logic sel, logic [1:0] wd, logic [3:0] f,
                     logic dv, logic [2:0] cx, logic [27:0] va);
    reg_wr = wr; reg_sel = sel; reg_wdata = wd; err_flags = f;
    acc_dvma = dv; acc_ctx = cx; acc_vaddr = va;
    @(posedge clk);
    model_step(wr, sel, wd, f, dv, cx, va);
    @(negedge clk);
    reg_wr = 1'b0; err_flags = '0; reg_sel = 1'b0;
    #1;
    chk(tag, "ecc status", rd_e, exp_status(0));
    chk(tag, "par status", rd_p, exp_status(1));
    chk(tag, "ecc irq", {31'h0, irq_e}, {31'h0, m_ie[0] & m_pend[0]});
    chk(tag, "par irq", {31'h0, irq_p}, {31'h0, m_ie[1] & m_pend[1]});
    reg_sel = 1'b1;
    #1;
    chk(tag, "ecc addr", rd_e, m_addr[0]);
    chk(tag, "par addr", rd_p, m_addr[1]);
    reg_sel = 1'b0;
  endtask

  task automatic idle(string tag);
    cyc(tag, 1'b0, 1'b0, 2'b00, 4'h0, 1'b0, 3'd0, 28'h0);
  endtask

  initial begin
    for (int m = 0; m < 2; m++) begin
      m_ie[m] = 0; m_en[m] = 0; m_pend[m] = 0; m_cause[m] = 0; m_addr[m] = 0;
    end
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    idle("R1");
    chk("R7", "ecc level", {29'h0, lvl_e}, 32'd7);
    chk("R7", "par level", {29'h0, lvl_p}, 32'd7);

    // R6 correctable ignored without enable; R4 parity lanes ignored without enable
    cyc("R6", 1'b0, 1'b0, 2'b00, 4'b0001, 1'b1, 3'd5, 28'h1234567);
    cyc("R4", 1'b0, 1'b0, 2'b00, 4'b1010, 1'b0, 3'd2, 28'h0abcdef);
    // R2 enables write; upper write data does not exist
    cyc("R2", 1'b1, 1'b0, 2'b10, 4'h0, 1'b0, 3'd0, 28'h0);
    // R5 uncorrectable (ECC) / lane 1 (parity), irq disabled so R7 low
    cyc("R5", 1'b0, 1'b0, 2'b00, 4'b0010, 1'b1, 3'd6, 28'hfedcba9);
    // R8 later error frozen out
    cyc("R8", 1'b0, 1'b0, 2'b00, 4'b1000, 1'b0, 3'd1, 28'h1111111);
    // R7 enable interrupt while pending
    cyc("R7", 1'b1, 1'b0, 2'b11, 4'h0, 1'b0, 3'd0, 28'h0);
    // R10 ack together with new error
    cyc("R10", 1'b1, 1'b1, 2'b00, 4'b0001, 1'b1, 3'd7, 28'h5a5a5a5);
    // R9 ack alone releases irq, enables kept
    cyc("R9", 1'b1, 1'b1, 2'b00, 4'h0, 1'b0, 3'd0, 28'h0);
    // R6 correctable accepted with enable; R3 address packing
    cyc("R3", 1'b0, 1'b0, 2'b00, 4'b0001, 1'b0, 3'd4, 28'h0c0ffee);
    cyc("R9", 1'b1, 1'b1, 2'b01, 4'h0, 1'b0, 3'd0, 28'h0);
    // R5 write-back causes both at once
    cyc("R5", 1'b0, 1'b0, 2'b00, 4'b1100, 1'b1, 3'd3, 28'h7777777);
    cyc("R10", 1'b1, 1'b1, 2'b00, 4'b0110, 1'b0, 3'd2, 28'h2468ace);

    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      int r;
      logic wr, sel;
      logic [3:0] f;
      r   = $urandom_range(0, 99);
      wr  = (r < 30);
      sel = (r >= 12);
      f   = ($urandom_range(0, 5) == 0) ? 4'($urandom_range(1, 15)) : 4'h0;
      cyc("R3/R8/R9", wr, sel, 2'($urandom_range(0, 3)), f, 1'($urandom_range(0, 1)),
          3'($urandom_range(0, 7)), 28'($urandom));
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule